// File: doc/BRIEF.md
# Four-Channel Bus-Master Control Register Bank

This block holds the bus-master control state for four storage channels behind a simple host register port. Each channel has a control word carrying a transfer-direction bit and an enable bit, and a descriptor-table base address. Channels 0 and 2 also have a second, read-only word that mirrors the control byte of the paired odd channel. The register state goes straight to a DMA engine as per-channel run, direction and base-address outputs. A one-cycle abort pulse is sent when software turns off a channel whose engine is still busy.

Two gating functions sit next to the registers. A task-file or PIO data access aimed at a channel whose bus mastering is enabled is answered with a target-abort indication in the same cycle. The four channel interrupt lines are merged onto one output. A steering bit, present only in channel 2's control word, chooses between two modes: pass every channel, or pass only the channel picked by the shadow device-select input.

Top module: `bmr_bank`

## Requirements
- R1: The channel register sets are decoded from reg_addr as follows. The channel number is {reg_addr[9], reg_addr[3]}, so channel bases are 000h, 008h, 200h and 208h. The control word is at base+0 and the table address is at base+4. The mirror word is at base+10h (010h, 018h, 210h, 218h). Any other address, including any with reg_addr[8:5] non-zero or reg_addr[1:0] non-zero, reads as 0, and a write to it changes no state.
- R2: In a control word, bit 3 is the direction (1 = device to memory, 0 = memory to device) and bit 0 is the enable. Both read back from the control word, and they drive dma_dir[ch] and dma_run[ch] from the clock edge that takes the write.
- R3: A control word reads 0 in bits 31:4 and in bit 2. Bit 1 reads 0 in channels 0, 1 and 3. In channel 2, bit 1 is the stored steering bit.
- R4: The table address word stores bits 31:2, reads 0 in bits 1:0 and resets to 0. The stored value appears on dma_tbl_base[32*ch +: 32].
- R5: The mirror word of channel 0 carries channel 1's control byte in bits 31:24, and the mirror word of channel 2 carries channel 3's control byte there. All other mirror bits read 0, including the simplex-only bit 23. The mirror words of channels 1 and 3 read 0. Writes to any mirror word are ignored.
- R6: tf_target_abort is high in the same cycle as tf_req when the channel named by tf_chan has its enable set. Otherwise it is low.
- R7: With the steering bit at 0, irq_out equals ch_irq[dev_sel]. With the steering bit at 1, irq_out is the OR of all four ch_irq bits.
- R8: A control write that clears a set enable while eng_busy[ch] is high makes dma_abort[ch] high for exactly the one cycle after that write's clock edge. The same write with eng_busy[ch] low gives no pulse.
- R9: After reset, every register is 0, so dma_run, dma_dir, dma_abort and the steering bit are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| tf_req | input | 1 | Task-file or PIO data access attempt |
| tf_chan | input | 2 | Channel addressed by that access |
| tf_target_abort | output | 1 | Access must complete with target-abort |
| eng_busy | input | 4 | Per-channel engine busy |
| dma_run | output | 4 | Per-channel bus-master enable |
| dma_dir | output | 4 | Per-channel direction, 1 = device to memory |
| dma_abort | output | 4 | Per-channel one-cycle abort pulse |
| dma_tbl_base | output | 128 | Per-channel descriptor table base, 32 bits each |
| ch_irq | input | 4 | Per-channel interrupt request |
| dev_sel | input | 2 | Shadow device-select, picks the passed channel |
| irq_out | output | 1 | Steered interrupt |

## Verification
The control write that clears a channel's enable and a task-file access to that same channel can arrive in the same cycle. The bench drives both together with the engine marked busy. Target-abort must be high before the edge, because the old enable still holds. After the edge, target-abort must be low while tf_req is still held, and the abort pulse for that channel must be present for that one cycle. The steering bit and the mirror words are also checked against writes made to neighbouring channels, to show that neither leaks across channels.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  localparam int NUM_CH   = 4;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int STEER_CH = 2;
  localparam int BYTE_W   = 8;

  typedef enum logic [1:0] {KIND_NONE, KIND_CTRL, KIND_TBL, KIND_MIRROR} reg_kind_e;

  // Register kind from a byte address; unmapped holes give KIND_NONE.
  function automatic reg_kind_e kind_of(input logic [ADDR_W-1:0] a);
    if (a[1:0] != 2'b00 || a[8:5] != 4'd0) return KIND_NONE;
    case ({a[4], a[2]})
      2'b00:   return KIND_CTRL;
      2'b01:   return KIND_TBL;
      2'b10:   return KIND_MIRROR;
      default: return KIND_NONE;
    endcase
  endfunction

  // Channel number: high half selects pair, bit 3 selects odd member.
  function automatic logic [CH_W-1:0] chan_of(input logic [ADDR_W-1:0] a);
    return {a[9], a[3]};
  endfunction

  // Control byte as seen by software.
  function automatic logic [BYTE_W-1:0] ctrl_byte(input logic dir, input logic steer,
                                                  input logic en);
    return {4'b0000, dir, 1'b0, steer, en};
  endfunction

  // Mirror word: neighbour byte in the top lane, simplex bit and rest zero.
  function automatic logic [DATA_W-1:0] mirror_word(input logic [BYTE_W-1:0] nb,
                                                    input logic has_mirror);
    return has_mirror ? {nb, {(DATA_W-BYTE_W){1'b0}}} : '0;
  endfunction
endpackage

// File: rtl/bmr_decode.sv
module bmr_decode
  import bmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [CH_W-1:0]   chan,
  output logic [NUM_CH-1:0] wr_ctrl,
  output logic [NUM_CH-1:0] wr_tbl
);
  always_comb begin
    kind    = kind_of(addr);
    chan    = chan_of(addr);
    wr_ctrl = '0;
    wr_tbl  = '0;
    if (wr && kind == KIND_CTRL) wr_ctrl[chan] = 1'b1;
    if (wr && kind == KIND_TBL)  wr_tbl[chan]  = 1'b1;
  end

  // R1
  write_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ctrl, wr_tbl}));

  // R1
  no_write_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |-> (wr_ctrl == '0 && wr_tbl == '0));
endmodule

// File: rtl/bmr_chan.sv
module bmr_chan
  import bmr_pkg::*;
#(
  parameter bit HAS_STEER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_tbl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output logic              en,
  output logic              dir,
  output logic              steer,
  output logic              abort,
  output logic [DATA_W-1:0] tbl_base
);
  localparam int TBL_LSB = 2;
  localparam int EN_BIT  = 0;
  localparam int ST_BIT  = 1;
  localparam int DIR_BIT = 3;

  logic [DATA_W-1:TBL_LSB] tbl_q;
  logic                    fall_evt;   // this write turns a set enable off

  assign fall_evt = wr_ctrl && !wdata[EN_BIT] && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      dir   <= 1'b0;
      abort <= 1'b0;
      tbl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en  <= wdata[EN_BIT];
        dir <= wdata[DIR_BIT];
      end
      if (wr_tbl) tbl_q <= wdata[DATA_W-1:TBL_LSB];
      abort <= fall_evt && busy;
    end
  end

  generate
    if (HAS_STEER) begin : g_steer
      always_ff @(posedge clk) begin
        if (!rst_n)       steer <= 1'b0;
        else if (wr_ctrl) steer <= wdata[ST_BIT];
      end
    end else begin : g_no_steer
      assign steer = 1'b0;
    end
  endgenerate

  assign tbl_base = {tbl_q, {TBL_LSB{1'b0}}};

  // R8
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  // R8
  abort_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!en && $past(en) && $past(busy)));

  // R4
  tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_tbl |=> $stable(tbl_base));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> ($stable(en) && $stable(dir) && $stable(steer)));
endmodule

// File: rtl/bmr_irq.sv
module bmr_irq
  import bmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              steer_all,
  input  logic [NUM_CH-1:0] ch_irq,
  input  logic [CH_W-1:0]   dev_sel,
  output logic              irq_out
);
  always_comb irq_out = steer_all ? (|ch_irq) : ch_irq[dev_sel];

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_irq == '0) |-> !irq_out);

  // R7
  irq_any_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (steer_all && ch_irq != '0) |-> irq_out);
endmodule

// File: rtl/bmr_bank.sv
module bmr_bank
  import bmr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic                     tf_req,
  input  logic [CH_W-1:0]          tf_chan,
  output logic                     tf_target_abort,
  input  logic [NUM_CH-1:0]        eng_busy,
  output logic [NUM_CH-1:0]        dma_run,
  output logic [NUM_CH-1:0]        dma_dir,
  output logic [NUM_CH-1:0]        dma_abort,
  output logic [NUM_CH*DATA_W-1:0] dma_tbl_base,
  input  logic [NUM_CH-1:0]        ch_irq,
  input  logic [CH_W-1:0]          dev_sel,
  output logic                     irq_out
);
  reg_kind_e         kind;
  logic [CH_W-1:0]   chan;
  logic [NUM_CH-1:0] wr_ctrl;
  logic [NUM_CH-1:0] wr_tbl;
  logic [NUM_CH-1:0] steer_v;
  logic [DATA_W-1:0] tbl_arr [NUM_CH];
  logic [CH_W-1:0]   pair_odd;       // odd channel mirrored into this pair

  bmr_decode u_dec (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .kind(kind), .chan(chan), .wr_ctrl(wr_ctrl), .wr_tbl(wr_tbl)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      bmr_chan #(.HAS_STEER(i == STEER_CH)) u_chan (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl[i]), .wr_tbl(wr_tbl[i]),
        .wdata(reg_wdata), .busy(eng_busy[i]),
        .en(dma_run[i]), .dir(dma_dir[i]), .steer(steer_v[i]),
        .abort(dma_abort[i]), .tbl_base(tbl_arr[i])
      );
      assign dma_tbl_base[i*DATA_W +: DATA_W] = tbl_arr[i];
    end
  endgenerate

  assign pair_odd = {chan[CH_W-1:1], 1'b1};

  always_comb begin
    reg_rdata = '0;
    case (kind)
      KIND_CTRL:   reg_rdata = {{(DATA_W-BYTE_W){1'b0}},
                                ctrl_byte(dma_dir[chan], steer_v[chan], dma_run[chan])};
      KIND_TBL:    reg_rdata = tbl_arr[chan];
      KIND_MIRROR: reg_rdata = mirror_word(ctrl_byte(dma_dir[pair_odd], steer_v[pair_odd],
                                                     dma_run[pair_odd]), !chan[0]);
      default:     reg_rdata = '0;
    endcase
  end

  assign tf_target_abort = tf_req && dma_run[tf_chan];

  bmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .steer_all(steer_v[STEER_CH]),
    .ch_irq(ch_irq), .dev_sel(dev_sel), .irq_out(irq_out)
  );

  // R3
  ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == KIND_CTRL) |-> (reg_rdata[2] == 1'b0 && reg_rdata[DATA_W-1:4] == '0));

  // R5
  mirror_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == KIND_MIRROR) |-> (reg_rdata[DATA_W-BYTE_W-1:0] == '0));

  // R5
  mirror_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && kind == KIND_MIRROR) |=> ($stable(dma_run) && $stable(dma_dir) && $stable(steer_v)));

  // R6
  tf_abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tf_target_abort |-> (tf_req && dma_run != '0));

  // R1
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == KIND_NONE) |-> (reg_rdata == '0));
endmodule

// File: tb/bmr_bank_tb_top.sv
`timescale 1ns/1ps
module bmr_bank_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [9:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         tf_req = 1'b0;
  logic [1:0]   tf_chan = '0;
  logic         tf_target_abort;
  logic [3:0]   eng_busy = '0;
  logic [3:0]   dma_run, dma_dir, dma_abort;
  logic [127:0] dma_tbl_base;
  logic [3:0]   ch_irq = '0;
  logic [1:0]   dev_sel = '0;
  logic         irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bmr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tf_req(tf_req),
    .tf_chan(tf_chan), .tf_target_abort(tf_target_abort), .eng_busy(eng_busy),
    .dma_run(dma_run), .dma_dir(dma_dir), .dma_abort(dma_abort),
    .dma_tbl_base(dma_tbl_base), .ch_irq(ch_irq), .dev_sel(dev_sel),
    .irq_out(irq_out)
  );

  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_RD = 2'd2;
  localparam int NV = 23;
  // {requirement number, op, address, write data or expected read}
  localparam logic [47:0] VEC [NV] = '{
    {4'd2, OP_WR, 10'h000, 32'hFFFF_FFFF},  // R2 ch0 dir+en, junk elsewhere
    {4'd3, OP_RD, 10'h000, 32'h0000_0009},  // R3 reserved bits clear, no steer
    {4'd4, OP_WR, 10'h00C, 32'h1234_5677},  // R4 ch1 table
    {4'd4, OP_RD, 10'h00C, 32'h1234_5674},  // R4 low bits read 0
    {4'd3, OP_WR, 10'h200, 32'h0000_0002},  // R3 ch2 steering on
    {4'd3, OP_RD, 10'h200, 32'h0000_0002},  // R3 steer readable in ch2
    {4'd3, OP_WR, 10'h208, 32'h0000_000B},  // R3 ch3 bit1 reserved
    {4'd3, OP_RD, 10'h208, 32'h0000_0009},  // R3
    {4'd5, OP_RD, 10'h210, 32'h0900_0000},  // R5 ch2 mirrors ch3
    {4'd5, OP_RD, 10'h010, 32'h0000_0000},  // R5 ch1 idle
    {4'd5, OP_WR, 10'h218, 32'hFFFF_FFFF},  // R5 write to odd mirror
    {4'd5, OP_RD, 10'h218, 32'h0000_0000},  // R5 odd mirror reads 0
    {4'd5, OP_RD, 10'h208, 32'h0000_0009},  // R5 ch3 untouched
    {4'd1, OP_WR, 10'h014, 32'hFFFF_FFFF},  // R1 hole
    {4'd1, OP_RD, 10'h014, 32'h0000_0000},  // R1
    {4'd4, OP_WR, 10'h204, 32'hFFFF_FFFF},  // R4 ch2 table
    {4'd4, OP_RD, 10'h204, 32'hFFFF_FFFC},  // R4
    {4'd1, OP_WR, 10'h008, 32'h0000_0001},  // R1 ch1 enable, dir 0
    {4'd5, OP_RD, 10'h010, 32'h0100_0000},  // R5 ch0 mirrors ch1
    {4'd1, OP_RD, 10'h004, 32'h0000_0000},  // R1 ch0 table unwritten
    {4'd1, OP_WR, 10'h0A0, 32'hFFFF_FFFF},  // R1 out-of-range address
    {4'd1, OP_RD, 10'h000, 32'h0000_0009},  // R1 ch0 unchanged
    {4'd1, OP_RD, 10'h00C, 32'h1234_5674}   // R1 ch1 table unchanged
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [9:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    tf_req = 1'b1; tf_chan = 2'd0;
    #1;
    check("R9 run", dma_run, 4'b0);
    check("R9 dir", dma_dir, 4'b0);
    check("R9 abort", dma_abort, 4'b0);
    check("R9 tf_abort", tf_target_abort, 1'b0);
    check("R9 irq", irq_out, 1'b0);
    tf_req = 1'b0;
    read_check("R9 ctrl2", 10'h200, 32'h0);
    read_check("R9 tbl0", 10'h004, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      if (v[43:42] == OP_WR) do_write(v[41:32], v[31:0]);
      else read_check($sformatf("R%0d vec%0d", v[47:44], i), v[41:32], v[31:0]);
    end

    // R2 engine outputs
    #1;
    check("R2 run", dma_run, 4'b1011);
    check("R2 dir", dma_dir, 4'b1001);
    // R4 base outputs
    check("R4 base ch2", dma_tbl_base[95:64], 32'hFFFF_FFFC);
    check("R4 base ch1", dma_tbl_base[63:32], 32'h1234_5674);

    // R6 task-file gating
    @(negedge clk);
    tf_req = 1'b1; tf_chan = 2'd0; #1 check("R6 ch0", tf_target_abort, 1'b1);
    tf_chan = 2'd2; #1 check("R6 ch2", tf_target_abort, 1'b0);
    tf_chan = 2'd3; #1 check("R6 ch3", tf_target_abort, 1'b1);
    tf_req = 1'b0;  #1 check("R6 no req", tf_target_abort, 1'b0);

    // R7 steering
    ch_irq = 4'b0100; dev_sel = 2'd0; #1 check("R7 all", irq_out, 1'b1);
    ch_irq = 4'b0000; #1 check("R7 none", irq_out, 1'b0);
    do_write(10'h200, 32'h0);
    ch_irq = 4'b0100; dev_sel = 2'd0; #1 check("R7 sel0", irq_out, 1'b0);
    dev_sel = 2'd2; #1 check("R7 sel2", irq_out, 1'b1);
    ch_irq = 4'b0000;

    // R8 abort on busy channel
    eng_busy = 4'b1000;
    do_write(10'h208, 32'h0000_0008);
    #1 check("R8 pulse", dma_abort, 4'b1000);
    @(negedge clk); #1 check("R8 one cycle", dma_abort, 4'b0000);
    read_check("R8 ch3 dir kept", 10'h208, 32'h0000_0008);
    eng_busy = 4'b0000;
    do_write(10'h008, 32'h0);
    #1 check("R8 idle no pulse", dma_abort, 4'b0000);

    // R6 with R8 in the same cycle
    do_write(10'h000, 32'h1);
    @(negedge clk);
    eng_busy = 4'b0001;
    reg_wr = 1'b1; reg_addr = 10'h000; reg_wdata = 32'h0;
    tf_req = 1'b1; tf_chan = 2'd0;
    #1 check("R6 before edge", tf_target_abort, 1'b1);
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
    check("R6 after edge", tf_target_abort, 1'b0);
    check("R8 joint pulse", dma_abort, 4'b0001);
    tf_req = 1'b0; eng_busy = 4'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule